// File: doc/BRIEF.md
# Time Slot Interchange Switch

This block reorders the 8-bit channels of a time-division multiplexed stream. Octets arrive one per strobe. A strobe flagged as start-of-frame carries slot 0, and the slots that follow count upward from there. Each octet is stored at the address equal to its slot number in one half of a two-bank frame store. In the same strobe cycle, the other bank is read. That bank holds the last complete frame.

A connection map has one entry per outgoing position. Each entry names the incoming slot that feeds that position, so any input can reach any output, and one input can feed several outputs. Each entry also has an idle flag that forces the fixed filler octet 0xFF. A host loads the map through a simple write/read port. Its writes go to a staging copy, which becomes live only at the next frame start, so the host never produces a frame that is half old map and half new map.

The outgoing stream mirrors the incoming strobes, one clock later. Its content lags the input by exactly one frame.

Top module: `tsi_switch`

## Requirements
- R1: After reset, `out_valid` is 0, every staged map entry reads back as the identity mapping (entry n = source n, idle flag 0), and every octet of the first frame after reset is 0xFF.
- R2: Within a frame, the k-th accepted strobe, counting the start-of-frame strobe as k=0, is stored as incoming slot k.
- R3: Outgoing position n of frame f carries incoming slot s of frame f-1, where s is the source field (bits [SW-1:0]) of live map entry n.
- R4: Any source may be mapped to any position, and one source may feed several positions in the same frame.
- R5: A live entry whose idle flag (bit SW of the map word) is 1 outputs 0xFF.
- R6: A host write becomes live at the first start-of-frame strobe that follows it. A write issued in the same cycle as a start-of-frame strobe is not live until the frame after that one.
- R7: One cycle after a write, `cfg_rdata` for the same address returns the staged word that was written.
- R8: Each accepted strobe produces exactly one `out_valid` pulse, one cycle later. `out_sof` is high on the pulse that follows a start-of-frame strobe.
- R9: Strobes beyond slot NSLOT-1 in a frame, and strobes that arrive before the first start-of-frame after reset, are dropped. They produce no output and write nothing.
- R10: Idle cycles (in_valid=0) between strobes of a frame do not change slot numbering or results.
- R11: A live entry whose source field is NSLOT or greater outputs 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming octet strobe |
| in_sof | input | 1 | Strobe carries slot 0 of a new frame |
| in_data | input | W | Incoming octet |
| out_valid | output | 1 | Outgoing octet strobe |
| out_sof | output | 1 | Outgoing octet is position 0 |
| out_data | output | W | Outgoing octet |
| cfg_we | input | 1 | Staged map write enable |
| cfg_addr | input | SW | Outgoing position being accessed |
| cfg_wdata | input | SW+1 | Map word: idle flag at bit SW, source in [SW-1:0] |
| cfg_rdata | output | SW+1 | Staged map word at cfg_addr |

## Verification
A host write can land in the same cycle as a start-of-frame strobe. On that cycle the block commits the staged map and also accepts a new staged word. The bench drives one map write during the slot-0 strobe of a frame. It then checks that the mapped position keeps its old source through that whole frame and switches in the next one. A second write issued in the middle of a frame, aimed at a position later in that same frame, must also leave that frame untouched.

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int NSLOT = 24,
  parameter int W = 8,
  parameter logic [W-1:0] IDLE_CODE = '1,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CW = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  output logic          out_sof,
  output logic [W-1:0]  out_data,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  output logic [CW-1:0] cfg_rdata
);
  localparam logic [SW:0] LIMIT = (SW+1)'(NSLOT);

  logic [W-1:0]  store [2][NSLOT];
  logic [CW-1:0] pend  [NSLOT];
  logic [CW-1:0] act   [NSLOT];
  logic          wr_bank;
  logic [SW:0]   wr_slot;

  logic [SW:0]   slot_now;
  logic          in_range;
  logic          eff_bank;
  logic [CW-1:0] map_word;
  logic [SW-1:0] src;
  logic [W-1:0]  rd_data;
  logic          cfg_ok;

  assign slot_now = in_sof ? '0 : wr_slot;
  assign in_range = slot_now < LIMIT;
  assign eff_bank = in_sof ? ~wr_bank : wr_bank;
  assign map_word = !in_range ? {1'b1, {SW{1'b0}}} :
                    in_sof    ? pend[slot_now[SW-1:0]] : act[slot_now[SW-1:0]];
  assign src      = map_word[SW-1:0];
  assign rd_data  = (map_word[SW] || ({1'b0, src} >= LIMIT)) ? IDLE_CODE
                                                           : store[~eff_bank][src];
  assign cfg_ok    = {1'b0, cfg_addr} < LIMIT;
  assign cfg_rdata = cfg_ok ? pend[cfg_addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < NSLOT; s++)
          store[b][s] <= IDLE_CODE;
      wr_bank <= 1'b1;
      wr_slot <= LIMIT;
    end else if (in_valid) begin
      if (in_range) begin
        store[eff_bank][slot_now[SW-1:0]] <= in_data;
        wr_slot <= slot_now + 1'b1;
      end
      wr_bank <= eff_bank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) begin
        pend[s] <= {1'b0, SW'(s)};
        act[s]  <= {1'b0, SW'(s)};
      end
    end else begin
      if (in_valid && in_sof)
        for (int s = 0; s < NSLOT; s++)
          act[s] <= pend[s];
      if (cfg_we && cfg_ok)
        pend[cfg_addr] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_data  <= IDLE_CODE;
    end else begin
      out_valid <= in_valid && in_range;
      out_sof   <= in_valid && in_sof;
      if (in_valid && in_range)
        out_data <= rd_data;
    end
  end
endmodule

module tsi_switch_chk #(
  parameter int NSLOT = 24,
  parameter int W = 8,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CW = SW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_sof,
  input logic          out_valid,
  input logic          out_sof,
  input logic          cfg_we,
  input logic [SW-1:0] cfg_addr,
  input logic [CW-1:0] cfg_wdata,
  input logic [CW-1:0] cfg_rdata
);
  a_r8_sof_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (out_valid && out_sof));
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_sof_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  a_r7_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && ({1'b0, cfg_addr} < (SW+1)'(NSLOT))) |=>
      ((cfg_addr != $past(cfg_addr)) || (cfg_rdata == $past(cfg_wdata))));
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

bind tsi_switch tsi_switch_chk #(.NSLOT(NSLOT), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .out_valid(out_valid), .out_sof(out_sof), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
);

// File: tb/sim_tsi_switch.sv
module sim_tsi_switch;
  localparam int CLK_P = 10;
  localparam int NSLOT = 24;
  localparam int SW = 5;
  localparam int CW = SW + 1;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0;
  logic [7:0] in_data = 0;
  logic out_valid, out_sof;
  logic [7:0] out_data;
  logic cfg_we = 0;
  logic [SW-1:0] cfg_addr = 0;
  logic [CW-1:0] cfg_wdata = 0;
  logic [CW-1:0] cfg_rdata;

  tsi_switch u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [8:0] exp_q[$];
  string tag_q[$];

  int pend_src[NSLOT], act_src[NSLOT];
  bit pend_idle[NSLOT], act_idle[NSLOT];
  int prev_m[NSLOT];
  int mid_beat = -1, mid_addr = 0, mid_src = 0;
  bit mid_idle = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) chk(0, "R8/R9 unexpected output", out_data, 0);
      else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({out_sof, out_data} == e, t, {out_sof, out_data}, e);
      end
    end
  end

  task automatic cfg_write(input int addr, input bit idle, input int src);
    cfg_we = 1; cfg_addr = SW'(addr); cfg_wdata = {idle, SW'(src)};
    @(negedge clk);
    cfg_we = 0;
    chk(cfg_rdata == {idle, SW'(src)}, "R7 staged readback", cfg_rdata, {idle, SW'(src)});
    pend_src[addr] = src; pend_idle[addr] = idle;
  endtask

  task automatic send_frame(input int nbeats, input int gap, input logic [7:0] base,
                            input logic [7:0] step, input string tag);
    int cur[NSLOT];
    for (int k = 0; k < nbeats; k++) begin
      logic [7:0] d;
      if (gap > 0 && k > 0 && k % gap == 0) begin
        in_valid = 0; in_sof = 0; cfg_we = 0;
        @(negedge clk);
      end
      d = base + 8'(step * k);
      in_valid = 1; in_sof = (k == 0); in_data = d;
      if (k == 0) begin
        act_src = pend_src; act_idle = pend_idle;
      end
      if (k == mid_beat) begin
        cfg_we = 1; cfg_addr = SW'(mid_addr); cfg_wdata = {mid_idle, SW'(mid_src)};
        pend_src[mid_addr] = mid_src; pend_idle[mid_addr] = mid_idle;
      end else cfg_we = 0;
      if (k < NSLOT) begin
        int e;
        e = (act_idle[k] || act_src[k] >= NSLOT) ? 8'hFF : prev_m[act_src[k]];
        exp_q.push_back({(k == 0), 8'(e)});
        tag_q.push_back($sformatf("%s slot %0d", tag, k));
        cur[k] = d;
      end
      @(negedge clk);
    end
    in_valid = 0; in_sof = 0; cfg_we = 0;
    prev_m = cur;
    mid_beat = -1;
  endtask

  initial begin
    #(CLK_P * 200000);
    chk(0, "watchdog (run hung)", 0, 1);
    summary();
  end

  initial begin
    for (int s = 0; s < NSLOT; s++) begin
      pend_src[s] = s; pend_idle[s] = 0; prev_m[s] = 8'hFF;
    end
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    foreach (pend_src[a]) if (a == 0 || a == 5 || a == 23) begin
      cfg_addr = SW'(a); #1;
      chk(cfg_rdata == CW'(a), "R1 identity map readback", cfg_rdata, a);
    end
    // R9: strobes before first sof are dropped
    for (int k = 0; k < 3; k++) begin
      in_valid = 1; in_sof = 0; in_data = 8'h55; @(negedge clk);
    end
    in_valid = 0; @(negedge clk);
    chk(exp_q.size() == 0, "R9 no output before first sof", exp_q.size(), 0);
    // R1: first frame all 0xFF; R2 stores slots in order
    send_frame(NSLOT, 0, 8'h10, 8'd1, "R1 first frame idle");
    // R3/R10: identity with gaps
    send_frame(NSLOT, 5, 8'h80, 8'd3, "R3 R10 identity one-frame lag");
    cfg_write(17, 0, 5);
    cfg_write(0, 0, 23);
    cfg_write(1, 0, 5);
    cfg_write(2, 1, 2);
    cfg_write(3, 0, 30);
    // R6 mid-frame write to a later position stays staged during this frame
    mid_beat = 10; mid_addr = 20; mid_src = 7; mid_idle = 0;
    send_frame(NSLOT, 0, 8'h20, 8'd5, "R4 R5 R11 R6 remapped frame");
    // R6 write during sof strobe is deferred one more frame
    mid_beat = 0; mid_addr = 6; mid_src = 9; mid_idle = 0;
    send_frame(NSLOT, 3, 8'hA0, 8'd7, "R6 sof-cycle write deferred");
    // R9 overlong frame
    send_frame(NSLOT + 2, 0, 8'h40, 8'd11, "R9 R6 overlong frame");
    send_frame(NSLOT, 0, 8'hC3, 8'd13, "R2 R3 after overlong");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all expected outputs seen", exp_q.size(), 0);
    summary();
  end
endmodule